// File: doc/BRIEF.md
# Compare-Match Watchdog and Interval Timer

The block counts ticks with a 7-bit up-counter and compares the count with a 7-bit value held in a software-written compare register. When a counted tick finds the counter equal to that value, the counter goes back to zero on that same tick and a match event fires. A mode bit in the control register sends the event one of two ways. It can leave as a one-cycle CPU reset request, which is watchdog use. It can instead set a sticky interrupt flag, which is periodic-timer use. In either case the period is the compare value plus one, counted in ticks.

Two tick sources are provided as single-cycle pulse inputs in the `clk` domain. `bit_tick` comes from an upstream interval prescaler of the system clock. `osc_tick` comes from an independent oscillator that keeps running when the main clock source is halted. That oscillator feeds a free-running 8-bit prescaler inside the block, so with this source one count equals 256 oscillator pulses. Software restarts the count by writing the compare register with its top bit set. This clear bit reads back as 1 for exactly one cycle and then drops to 0 by itself.

Top module: `cmwdt_top`

## Requirements
- R1: After reset the compare register reads 0x7F, with its clear bit at 0. The control register and the counter read 0, and `rst_req` and `irq_flag` are low.
- R2: The counter rises by exactly one on each tick of the selected source. In a cycle with no selected tick and no clear, it holds its value.
- R3: A selected tick that finds the counter equal to the compare value loads the counter with 0 and raises a match, so the period is compare value + 1 ticks. If the compare value is set below the current count, the counter runs up to 127, wraps to 0 and then reaches the compare value.
- R4: A write to the compare register (address 0) with bit 7 = 1 loads the counter and the oscillator prescaler with 0. In the next cycle bit 7 of that register reads 1, and after that it reads 0. A clear that falls in the same cycle as a tick wins: the counter becomes 0 and no match is raised.
- R5: With control bit 0 = 1 (reset mode), a match drives `rst_req` high for the one cycle after the matching tick and leaves `irq_flag` unchanged.
- R6: With control bit 0 = 0, a match sets `irq_flag` in the cycle after the matching tick. The flag stays set until a control write (address 1) with bit 2 = 1 clears it. A match in the same cycle as such a write leaves the flag set.
- R7: Control bit 1 picks the tick source: 0 selects `bit_tick`, and 1 selects one count per 256 `osc_tick` pulses. The source that is not selected has no effect on the counter.
- R8: `rd_data` is combinational from `rd_addr`. Address 0 gives {clear bit, compare value}. Address 1 gives {5'b0, irq_flag, source bit, mode bit}. Address 2 gives {1'b0, counter}. Address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 compare/clear, 1 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| bit_tick | input | 1 | Interval-timer tick pulse |
| osc_tick | input | 1 | Independent oscillator pulse |
| rst_req | output | 1 | One-cycle CPU reset request |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can land in the same cycle. A clear write can coincide with a matching tick, and a match can coincide with a software write that clears the interrupt flag. The bench drives each pair on purpose at a known count. It then judges the counter through the read port and the flag at the outputs: the clear must win in the first case, and the set must win in the second. A constrained-random phase then mixes writes, both tick sources and small compare values, so that such collisions recur against a per-cycle model.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // register addresses of the write and read port
  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } wdt_sel_e;

  // bit positions inside the control register
  localparam int unsigned CTL_MODE = 0;
  localparam int unsigned CTL_SRC  = 1;
  localparam int unsigned CTL_IRQ  = 2;

  typedef struct packed {
    logic src_osc;
    logic rst_mode;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W:0]   wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             irq_flag,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             clear_req,
  output wdt_ctrl_t        ctrl,
  output logic             irq_clr_req,
  output logic [CNT_W:0]   rd_data
);
  logic             cmp_wr, ctl_wr;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             clr_q, clr_d;
  wdt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-3:0] unused_ctrl_bits;

  assign unused_ctrl_bits = wr_data[CNT_W:3];

  always_comb begin
    cmp_wr = wr_en && (wr_addr == SEL_CMP);
    ctl_wr = wr_en && (wr_addr == SEL_CTRL);
    cmp_d  = cmp_q;
    ctrl_d = ctrl_q;
    if (cmp_wr) begin
      cmp_d = wr_data[CNT_W-1:0];
    end
    if (ctl_wr) begin
      ctrl_d.src_osc  = wr_data[CTL_SRC];
      ctrl_d.rst_mode = wr_data[CTL_MODE];
    end
    clr_d       = cmp_wr && wr_data[CNT_W];
    irq_clr_req = ctl_wr && wr_data[CTL_IRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      clr_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      cmp_q  <= cmp_d;
      clr_q  <= clr_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign cmp       = cmp_q;
  assign ctrl      = ctrl_q;
  assign clear_req = clr_d;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      SEL_CMP:  rd_data = {clr_q, cmp_q};
      SEL_CTRL: begin
        rd_data[CTL_MODE] = ctrl_q.rst_mode;
        rd_data[CTL_SRC]  = ctrl_q.src_osc;
        rd_data[CTL_IRQ]  = irq_flag;
      end
      SEL_CNT:  rd_data = {1'b0, cnt};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic clear,
  output logic ovf
);
  generate
    if (PRE_W == 0) begin : g_bypass
      logic unused_clear;
      assign unused_clear = clear;
      assign ovf = osc_tick;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      always_comb begin
        pre_en = clear || osc_tick;
        pre_d  = clear ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign ovf = osc_tick && !clear && (&pre_q);
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    match  = tick && !clear && (cnt_q == cmp);
    cnt_en = tick || clear;
    if (clear || match) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_action.sv
`timescale 1ns/1ps
module wdt_action (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic rst_mode,
  input  logic irq_clr,
  output logic rst_req,
  output logic irq_flag
);
  logic rst_q, rst_d;
  logic irq_q, irq_d;

  always_comb begin
    rst_d = match && rst_mode;
    irq_d = (match && !rst_mode) || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      irq_q <= irq_d;
    end
  end

  assign rst_req  = rst_q;
  assign irq_flag = irq_q;
endmodule

// File: rtl/cmwdt_top.sv
`timescale 1ns/1ps
module cmwdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W:0]   wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W:0]   rd_data,
  input  logic             bit_tick,
  input  logic             osc_tick,
  output logic             rst_req,
  output logic             irq_flag
);
  logic [CNT_W-1:0] cmp_val, cnt_val;
  logic             clear_req, irq_clr_req, pre_ovf, cnt_tick, match;
  wdt_ctrl_t        ctrl;

  wdt_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .irq_flag(irq_flag),
    .cnt(cnt_val), .cmp(cmp_val), .clear_req(clear_req), .ctrl(ctrl),
    .irq_clr_req(irq_clr_req), .rd_data(rd_data)
  );

  wdt_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .clear(clear_req),
    .ovf(pre_ovf)
  );

  assign cnt_tick = ctrl.src_osc ? pre_ovf : bit_tick;

  wdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .clear(clear_req),
    .cmp(cmp_val), .cnt(cnt_val), .match(match)
  );

  wdt_action act_i (
    .clk(clk), .rst_n(rst_n), .match(match), .rst_mode(ctrl.rst_mode),
    .irq_clr(irq_clr_req), .rst_req(rst_req), .irq_flag(irq_flag)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W:0]   wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cnt_tick,
  input logic             rst_mode,
  input logic             rst_req,
  input logic             irq_flag
);
  logic clr_wr, irq_wc;
  assign clr_wr = wr_en && (wr_addr == 2'd0) && wr_data[CNT_W];
  assign irq_wc = wr_en && (wr_addr == 2'd1) && wr_data[2];

  // R4: a clear write leaves the counter at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0));

  // R2: no tick and no clear, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !clr_wr) |=> $stable(cnt));

  // R3: a non-matching tick advances by one
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !clr_wr && (cnt != cmp)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3: a matching tick returns to zero
  a_r3_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !clr_wr && (cnt == cmp)) |=> (cnt == '0));

  // R5: a reset request only comes from reset mode
  a_r5_req_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_mode));

  // R6: the flag only rises in interrupt mode
  a_r6_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> !$past(rst_mode));

  // R6: the flag holds without a clearing write
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_wc) |=> irq_flag);
endmodule

bind cmwdt_top wdt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt(cnt_val), .cmp(cmp_val), .cnt_tick(cnt_tick),
  .rst_mode(ctrl.rst_mode), .rst_req(rst_req), .irq_flag(irq_flag)
);

// File: tb/cmwdt_tb_top.sv
`timescale 1ns/1ps
module cmwdt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic       bit_tick = 1'b0;
  logic       osc_tick = 1'b0;
  logic [7:0] rd_data;
  logic       rst_req, irq_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  cmwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bit_tick(bit_tick), .osc_tick(osc_tick), .rst_req(rst_req),
    .irq_flag(irq_flag)
  );

  // reference state built from the requirements
  logic [6:0] m_cnt, m_cmp;
  logic [7:0] m_pre;
  logic       m_clr, m_mode, m_src, m_irq, m_rst;

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_clr, m_cmp};
      2'd1:    return {5'b0, m_irq, m_src, m_mode};
      2'd2:    return {1'b0, m_cnt};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic clrw, ovf, tk, mt;
    if (!rst_n) begin
      m_cnt = 7'd0; m_cmp = 7'h7F; m_pre = 8'd0; m_clr = 1'b0;
      m_mode = 1'b0; m_src = 1'b0; m_irq = 1'b0; m_rst = 1'b0;
    end else begin
      clrw = wr_en && wr_addr == 2'd0 && wr_data[7];
      ovf  = osc_tick && !clrw && m_pre == 8'hFF;
      tk   = m_src ? ovf : bit_tick;
      mt   = tk && !clrw && m_cnt == m_cmp;
      m_rst = mt && m_mode;
      m_irq = (mt && !m_mode) || (m_irq && !(wr_en && wr_addr == 2'd1 && wr_data[2]));
      if (clrw) m_pre = 8'd0; else if (osc_tick) m_pre = m_pre + 8'd1;
      if (clrw || mt) m_cnt = 7'd0; else if (tk) m_cnt = m_cnt + 7'd1;
      m_clr = clrw;
      if (wr_en && wr_addr == 2'd0) m_cmp = wr_data[6:0];
      if (wr_en && wr_addr == 2'd1) begin
        m_mode = wr_data[0];
        m_src  = wr_data[1];
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: compare against the model, then drive the next inputs
  task automatic step(input logic b, input logic o, input logic w,
                      input logic [1:0] a, input logic [7:0] d, input logic [1:0] ra);
    @(negedge clk);
    if (rst_n) begin
      chk(rd_data, model_read(rd_addr), "R8 model read");
      chk({6'd0, rst_req, irq_flag}, {6'd0, m_rst, m_irq}, "R5/R6 model outputs");
    end
    bit_tick = b; osc_tick = o; wr_en = w; wr_addr = a; wr_data = d; rd_addr = ra;
    #1;
  endtask

  task automatic idle(input logic [1:0] ra);
    step(1'b0, 1'b0, 1'b0, 2'd0, 8'd0, ra);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'd0, 2'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(2'd0); chk(rd_data, 8'h7F, "R1 compare reset");
    idle(2'd1); chk(rd_data, 8'h00, "R1 control reset");
    idle(2'd2); chk(rd_data, 8'h00, "R1 counter reset");
    chk({6'd0, rst_req, irq_flag}, 8'h00, "R1 outputs low");

    // R4 clear bit, R3 period, R6 interrupt
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h83, 2'd0);
    idle(2'd0); chk(rd_data, 8'h83, "R4 clear bit visible");
    idle(2'd0); chk(rd_data, 8'h03, "R4 clear bit self-clears");
    ticks(3);
    idle(2'd2); chk(rd_data, 8'h03, "R3 count before match");
    chk({7'd0, irq_flag}, 8'h00, "R6 no flag before match");
    ticks(1);
    idle(2'd1); chk(rd_data, 8'h04, "R6 R8 flag in control read");
    idle(2'd2); chk(rd_data, 8'h00, "R3 wrap on match");

    // R6 write-one clears the flag
    step(1'b0, 1'b0, 1'b1, 2'd1, 8'h04, 2'd1);
    idle(2'd1); chk({7'd0, irq_flag}, 8'h00, "R6 flag cleared");

    // R4 clear with a matching tick wins
    ticks(3);
    step(1'b1, 1'b0, 1'b1, 2'd0, 8'h83, 2'd2);
    idle(2'd2); chk(rd_data, 8'h00, "R4 clear beats tick");
    chk({7'd0, irq_flag}, 8'h00, "R4 no match under clear");

    // R6 set beats clear
    ticks(3);
    step(1'b1, 1'b0, 1'b1, 2'd1, 8'h04, 2'd2);
    idle(2'd1); chk({7'd0, irq_flag}, 8'h01, "R6 set beats clear");

    // R2 hold, R7 osc ignored while bit source selected
    ticks(2);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 2'd0, 8'd0, 2'd2);
    chk(rd_data, 8'h02, "R2 R7 hold without selected tick");

    // R5 reset mode
    step(1'b0, 1'b0, 1'b1, 2'd1, 8'h05, 2'd2);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h82, 2'd2);
    ticks(3);
    idle(2'd1); chk({7'd0, rst_req}, 8'h01, "R5 reset pulse");
    chk({7'd0, irq_flag}, 8'h00, "R5 flag untouched");
    idle(2'd1); chk({7'd0, rst_req}, 8'h00, "R5 pulse one cycle");

    // R3 compare lowered below count
    step(1'b0, 1'b0, 1'b1, 2'd1, 8'h00, 2'd2);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'hFF, 2'd2);
    ticks(3);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 2'd2);
    ticks(124);
    idle(2'd2); chk(rd_data, 8'h7F, "R3 runs to top");
    ticks(1);
    idle(2'd2); chk(rd_data, 8'h00, "R3 natural wrap");
    chk({7'd0, irq_flag}, 8'h00, "R3 no match at wrap");
    ticks(2);
    idle(2'd2); chk({7'd0, irq_flag}, 8'h01, "R3 match after wrap");

    // R7 oscillator source, divide by 256
    step(1'b0, 1'b0, 1'b1, 2'd1, 8'h06, 2'd2);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h85, 2'd2);
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 8'd0, 2'd2);
    idle(2'd2); chk(rd_data, 8'h00, "R7 no count before 256");
    step(1'b0, 1'b1, 1'b0, 2'd0, 8'd0, 2'd2);
    idle(2'd2); chk(rd_data, 8'h01, "R7 count at 256");

    // random phase against the model (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom % 4);
      if (a == 2'd0) d = {($urandom % 4) == 0, 7'($urandom % 6)};
      else d = 8'($urandom);
      step(1'($urandom % 2), ($urandom % 4) != 0, ($urandom % 8) == 0,
           a, d, 2'($urandom % 4));
    end
    idle(2'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule